// File: doc/BRIEF.md
# Three-Minimum Column-Layered Check Node

This block is the check-node processor for one parity-check row of a min-sum LDPC decoder that sweeps the code one block column at a time. It does not hold every incoming message of the row. It keeps a short sorted record: the three smallest variable-to-check magnitudes seen so far, the block-column index each one came from, and the parity (XOR) of the signs of every edge of the row. Each column-layer cycle names one block column, supplies the sign this edge carried before and the fresh variable-to-check message, and receives the check-to-variable message for that column one cycle later.

The record changes in two stages within each cycle. First the current column is taken out: it is found by index compare and the list is compacted. The smallest remaining magnitude, with the sign parity corrected for the old edge sign, forms the outgoing message. The new magnitude is then sorted back in. A simplified insertion mode uses only two ordering comparisons. A second read port computes a predicted message for a column two layers ahead from the record as it stood before the current update, so the variable-node loop can be pipelined. Before the first iteration the record is built from an empty state, one block column per cycle.

Top module: `cn3_check_node`

## Requirements
- R1: After reset both output valid flags are low and the record is empty, so a prediction request returns magnitude 7 and a sign equal to the supplied old sign.
- R2: While `build_i` is high, every `valid_i` cycle sorts its magnitude and index into the record using full three-position insertion and XORs `new_sign_i` into the sign parity. `old_sign_i` is ignored and no message is produced.
- R3: On a layer cycle (`valid_i` high, `build_i` and `clear_i` low), an entry whose index equals `layer_i` is removed and the list is compacted. `msg_o[2:0]` is the smallest magnitude left after removal. If no index matches, it is the smallest stored magnitude.
- R4: `msg_o[3]`, the message sign (1 = negative), equals the stored sign parity XOR `old_sign_i`.
- R5: With `simple_i` low, the new magnitude is inserted in ascending order behind any stored entry of equal magnitude. A value that would land after the third position is dropped.
- R6: When no valid entry remains after removal, the message magnitude saturates to 7.
- R7: With `simple_i` high on a layer cycle, if no index matched and the second entry is valid and not larger than the new magnitude, the stored magnitudes and indices stay unchanged.
- R8: On a layer cycle the sign parity becomes its old value XOR `old_sign_i` XOR `new_sign_i`.
- R9: A cycle with `pred_req_i` high and `build_i` low yields, one cycle later, `pred_valid_o` and `pred_o`. These are computed like R3, R4 and R6, for `pred_layer_i` and `pred_old_sign_i`, from the record as it stood before that cycle's update.
- R10: `clear_i` empties the record and zeroes the sign parity. It takes priority over `valid_i` in the same cycle, and that cycle produces no message.
- R11: `msg_valid_o` rises exactly one cycle after each layer cycle and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Empty the record |
| build_i | input | 1 | Initial record building mode |
| simple_i | input | 1 | Two-comparison insertion mode |
| valid_i | input | 1 | A column is presented this cycle |
| layer_i | input | 5 | Block-column index of the current layer |
| old_sign_i | input | 1 | Previous sign of this edge |
| new_mag_i | input | 3 | Fresh variable-to-check magnitude |
| new_sign_i | input | 1 | Fresh variable-to-check sign |
| pred_req_i | input | 1 | Request a predicted message |
| pred_layer_i | input | 5 | Block column of the prediction |
| pred_old_sign_i | input | 1 | Stored sign of the predicted edge |
| msg_valid_o | output | 1 | Message valid |
| msg_o | output | 4 | Check-to-variable message, sign in bit 3 |
| pred_valid_o | output | 1 | Predicted message valid |
| pred_o | output | 4 | Predicted message, sign in bit 3 |

## Verification
The assertions watch, on every cycle, several standing properties. The stored entries stay sorted and packed toward position one, and no block-column index appears twice. A clear leaves the record empty. Build cycles emit nothing. A simplified-mode discard leaves the record untouched, and both valid flags follow their requests by exactly one cycle. Only the bench scenarios can show that the message values are right: the removal result, the sign parity over a whole sweep, tie ordering, the dropped fourth value, saturation on an empty list, and predictions taken from the stale record. The scoreboard checks these against a reference record kept in the bench.

// File: rtl/cn3_pkg.sv
package cn3_pkg;
  localparam int MAG_W = 3;
  localparam int NCOL  = 32;
  localparam int IDX_W = $clog2(NCOL);
  localparam int NKEEP = 3;
  localparam int POS_W = $clog2(NKEEP + 1);
  localparam logic [MAG_W-1:0] MAG_SAT = '1;

  typedef struct packed {
    logic             v;
    logic [MAG_W-1:0] mag;
    logic [IDX_W-1:0] idx;
  } entry_t;

  typedef entry_t [NKEEP-1:0] list_t;
endpackage

// File: rtl/cn3_remove.sv
// Takes the entry carrying idx_i out of a sorted list and compacts the rest
// toward position 0; the freed last slot becomes void.
module cn3_remove
  import cn3_pkg::*;
(
  input  list_t            ent_i,
  input  logic [IDX_W-1:0] idx_i,
  output list_t            ent_o
);
  logic [NKEEP-1:0] match;
  logic [POS_W-1:0] rpos;

  for (genvar k = 0; k < NKEEP; k++) begin : g_cmp
    assign match[k] = ent_i[k].v && (ent_i[k].idx == idx_i);
  end

  always_comb begin
    rpos = POS_W'(NKEEP);
    for (int k = NKEEP - 1; k >= 0; k--) begin
      if (match[k]) rpos = POS_W'(k);
    end
  end

  for (genvar k = 0; k < NKEEP; k++) begin : g_shift
    if (k < NKEEP - 1) begin : g_mid
      assign ent_o[k] = (rpos <= POS_W'(k)) ? ent_i[k+1] : ent_i[k];
    end else begin : g_last
      assign ent_o[k] = (rpos <= POS_W'(k)) ? entry_t'('0) : ent_i[k];
    end
  end
endmodule

// File: rtl/cn3_insert.sv
// Sorts a new magnitude into a compacted list. Full mode compares against all
// positions; simplified mode compares only the first NKEEP-1 and appends to
// the freed slot when a removal took place.
module cn3_insert
  import cn3_pkg::*;
(
  input  list_t            orig_i,
  input  list_t            cmp_i,
  input  logic             full_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [IDX_W-1:0] idx_i,
  output list_t            ent_o,
  output logic             change_o
);
  logic [NKEEP-1:0] lt;
  logic [POS_W-1:0] ipos;
  logic             hit;
  entry_t           new_ent;

  // Indices in the record are unique, so compaction alters the list exactly
  // when an entry was removed.
  assign hit     = (cmp_i != orig_i);
  assign new_ent = '{v: 1'b1, mag: mag_i, idx: idx_i};

  for (genvar k = 0; k < NKEEP; k++) begin : g_lt
    assign lt[k] = !cmp_i[k].v || (mag_i < cmp_i[k].mag);
  end

  always_comb begin
    ipos = POS_W'(NKEEP);
    for (int k = NKEEP - 1; k >= 0; k--) begin
      if (lt[k] && (full_i || (k < NKEEP - 1))) ipos = POS_W'(k);
    end
    if (!full_i && hit && (ipos == POS_W'(NKEEP))) ipos = POS_W'(NKEEP - 1);
  end

  for (genvar k = 0; k < NKEEP; k++) begin : g_place
    if (k == 0) begin : g_head
      assign ent_o[k] = (ipos == POS_W'(0)) ? new_ent : cmp_i[k];
    end else begin : g_tail
      assign ent_o[k] = (ipos == POS_W'(k)) ? new_ent :
                        (ipos <  POS_W'(k)) ? cmp_i[k-1] : cmp_i[k];
    end
  end

  assign change_o = hit || (ipos != POS_W'(NKEEP));
endmodule

// File: rtl/cn3_msg.sv
// Forms a sign-magnitude check-to-variable message from a compacted list.
module cn3_msg
  import cn3_pkg::*;
(
  input  list_t            ent_i,
  input  logic             sp_i,
  input  logic             old_sign_i,
  output logic [MAG_W:0]   msg_o
);
  assign msg_o = {sp_i ^ old_sign_i, ent_i[0].v ? ent_i[0].mag : MAG_SAT};
endmodule

// File: rtl/cn3_check_node.sv
module cn3_check_node
  import cn3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             build_i,
  input  logic             simple_i,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] layer_i,
  input  logic             old_sign_i,
  input  logic [MAG_W-1:0] new_mag_i,
  input  logic             new_sign_i,
  input  logic             pred_req_i,
  input  logic [IDX_W-1:0] pred_layer_i,
  input  logic             pred_old_sign_i,
  output logic             msg_valid_o,
  output logic [MAG_W:0]   msg_o,
  output logic             pred_valid_o,
  output logic [MAG_W:0]   pred_o
);
  list_t          ent_q, ent_d, cur_cmp, pred_cmp, ins_ent;
  logic           sp_q, sp_d;
  logic           ent_en, sp_en, ins_change;
  logic           layer_cyc, pred_cyc;
  logic [MAG_W:0] cur_msg, pred_msg;

  // Current layer: removal, message, insertion
  cn3_remove i_rm_cur (.ent_i(ent_q), .idx_i(layer_i), .ent_o(cur_cmp));

  cn3_msg i_msg_cur (
    .ent_i(cur_cmp), .sp_i(sp_q), .old_sign_i(old_sign_i), .msg_o(cur_msg)
  );

  cn3_insert i_ins (
    .orig_i(ent_q), .cmp_i(cur_cmp), .full_i(build_i || !simple_i),
    .mag_i(new_mag_i), .idx_i(layer_i), .ent_o(ins_ent), .change_o(ins_change)
  );

  // Look-ahead path: message for a later layer from the stale record
  cn3_remove i_rm_pred (.ent_i(ent_q), .idx_i(pred_layer_i), .ent_o(pred_cmp));

  cn3_msg i_msg_pred (
    .ent_i(pred_cmp), .sp_i(sp_q), .old_sign_i(pred_old_sign_i), .msg_o(pred_msg)
  );

  assign layer_cyc = valid_i && !build_i && !clear_i;
  assign pred_cyc  = pred_req_i && !build_i;

  // Next-state
  always_comb begin
    ent_d  = ins_ent;
    sp_d   = sp_q ^ new_sign_i ^ (old_sign_i && !build_i);
    ent_en = valid_i && ins_change;
    sp_en  = valid_i;
    if (clear_i) begin
      ent_d  = '0;
      sp_d   = 1'b0;
      ent_en = 1'b1;
      sp_en  = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (ent_en) begin
      ent_q <= ent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= 1'b0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid_o  <= 1'b0;
      pred_valid_o <= 1'b0;
    end else begin
      msg_valid_o  <= layer_cyc;
      pred_valid_o <= pred_cyc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_o <= '0;
    end else if (layer_cyc) begin
      msg_o <= cur_msg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_o <= '0;
    end else if (pred_cyc) begin
      pred_o <= pred_msg;
    end
  end
endmodule

// File: rtl/cn3_check_node_sva.sv
module cn3_check_node_sva
  import cn3_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             build_i,
  input logic             simple_i,
  input logic             valid_i,
  input logic [IDX_W-1:0] layer_i,
  input logic [MAG_W-1:0] new_mag_i,
  input logic             pred_req_i,
  input logic             msg_valid_o,
  input logic             pred_valid_o,
  input list_t            rec,
  input logic             sp
);
  logic armed;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NKEEP; k++) begin
      if (rec[k].v && rec[k].idx == layer_i) hit = 1'b1;
    end
  end

  AST_MSG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (msg_valid_o == $past(valid_i && !build_i && !clear_i))); // R11

  AST_PRED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pred_valid_o == $past(pred_req_i && !build_i))); // R9

  AST_BUILD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    build_i |=> !msg_valid_o); // R2

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!rec[0].v && !rec[1].v && !rec[2].v && !sp)); // R10

  AST_SIMPLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (simple_i && valid_i && !build_i && !clear_i && !hit && rec[1].v &&
     new_mag_i >= rec[1].mag) |=> $stable(rec)); // R7

  for (genvar k = 1; k < NKEEP; k++) begin : g_ord
    AST_SORTED_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
      rec[k].v |-> (rec[k-1].v && rec[k-1].mag <= rec[k].mag)); // R5
    AST_UNIQUE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (rec[k].v && rec[k-1].v) |-> (rec[k].idx != rec[k-1].idx)); // R3
  end

  AST_UNIQUE_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rec[2].v && rec[0].v) |-> (rec[2].idx != rec[0].idx)); // R3
endmodule

bind cn3_check_node cn3_check_node_sva i_cn3_sva (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .build_i(build_i),
  .simple_i(simple_i), .valid_i(valid_i), .layer_i(layer_i),
  .new_mag_i(new_mag_i), .pred_req_i(pred_req_i), .msg_valid_o(msg_valid_o),
  .pred_valid_o(pred_valid_o), .rec(ent_q), .sp(sp_q)
);

// File: tb/test_cn3_check_node.sv
module test_cn3_check_node;
  logic       clk;
  logic       rst_n;
  logic       clear_i, build_i, simple_i, valid_i;
  logic [4:0] layer_i;
  logic       old_sign_i;
  logic [2:0] new_mag_i;
  logic       new_sign_i;
  logic       pred_req_i;
  logic [4:0] pred_layer_i;
  logic       pred_old_sign_i;
  logic       msg_valid_o, pred_valid_o;
  logic [3:0] msg_o, pred_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  cn3_check_node i_cn3_check_node (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .build_i(build_i),
    .simple_i(simple_i), .valid_i(valid_i), .layer_i(layer_i),
    .old_sign_i(old_sign_i), .new_mag_i(new_mag_i), .new_sign_i(new_sign_i),
    .pred_req_i(pred_req_i), .pred_layer_i(pred_layer_i),
    .pred_old_sign_i(pred_old_sign_i), .msg_valid_o(msg_valid_o),
    .msg_o(msg_o), .pred_valid_o(pred_valid_o), .pred_o(pred_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference record
  logic       m_v[3];
  logic [2:0] m_mag[3];
  logic [4:0] m_idx[3];
  logic       m_sp;
  logic       t_v[3];
  logic [2:0] t_mag[3];
  logic [4:0] t_idx[3];
  logic       t_hit;
  logic       edge_sign[32];

  logic [3:0] exp_msg_q[$];
  string      msg_tag_q[$];
  logic [3:0] exp_pred_q[$];
  string      pred_tag_q[$];

  task automatic check(input bit ok, input string req, input logic [3:0] act,
                       input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mdl_compact(input logic [4:0] idx);
    int r;
    r = 3;
    for (int k = 0; k < 3; k++) if (r == 3 && m_v[k] && m_idx[k] == idx) r = k;
    t_hit = (r != 3);
    for (int k = 0; k < 3; k++) begin
      if (k < r) begin
        t_v[k] = m_v[k]; t_mag[k] = m_mag[k]; t_idx[k] = m_idx[k];
      end else if (k < 2) begin
        t_v[k] = m_v[k+1]; t_mag[k] = m_mag[k+1]; t_idx[k] = m_idx[k+1];
      end else begin
        t_v[k] = 1'b0; t_mag[k] = '0; t_idx[k] = '0;
      end
    end
  endtask

  function automatic logic [3:0] mdl_msg(input logic osg);
    return {m_sp ^ osg, t_v[0] ? t_mag[0] : 3'd7};
  endfunction

  task automatic mdl_insert(input logic [2:0] mag, input logic [4:0] idx, input bit full);
    int p;
    p = 3;
    for (int k = 2; k >= 0; k--)
      if ((full || k < 2) && (!t_v[k] || mag < t_mag[k])) p = k;
    if (!full && p == 3 && t_hit) p = 2;
    for (int k = 0; k < 3; k++) begin
      if (p == 3 || k < p) begin
        m_v[k] = t_v[k]; m_mag[k] = t_mag[k]; m_idx[k] = t_idx[k];
      end else if (k == p) begin
        m_v[k] = 1'b1; m_mag[k] = mag; m_idx[k] = idx;
      end else begin
        m_v[k] = t_v[k-1]; m_mag[k] = t_mag[k-1]; m_idx[k] = t_idx[k-1];
      end
    end
  endtask

  task automatic mdl_clear();
    for (int k = 0; k < 3; k++) begin
      m_v[k] = 1'b0; m_mag[k] = '0; m_idx[k] = '0;
    end
    m_sp = 1'b0;
  endtask

  // Driver: one cycle of stimulus, expected results pushed to the scoreboard
  task automatic cyc(input bit clr, input bit bld, input bit smp, input bit vld,
                     input logic [4:0] lay, input bit osg, input logic [2:0] nmag,
                     input bit nsg, input bit prq, input logic [4:0] play,
                     input bit posg, input string tag);
    @(negedge clk);
    clear_i = clr; build_i = bld; simple_i = smp; valid_i = vld;
    layer_i = lay; old_sign_i = osg; new_mag_i = nmag; new_sign_i = nsg;
    pred_req_i = prq; pred_layer_i = play; pred_old_sign_i = posg;
    if (prq && !bld) begin
      mdl_compact(play);
      exp_pred_q.push_back(mdl_msg(posg));
      pred_tag_q.push_back({tag, " R9"});
    end
    if (clr) begin
      mdl_clear();
    end else if (vld) begin
      mdl_compact(lay);
      if (!bld) begin
        exp_msg_q.push_back(mdl_msg(osg));
        msg_tag_q.push_back(tag);
      end
      mdl_insert(nmag, lay, bld || !smp);
      m_sp = m_sp ^ nsg ^ (osg && !bld);
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 5'd0, 0, 3'd0, 0, 0, 5'd0, 0, "idle");
  endtask

  task automatic build_col(input logic [4:0] c, input logic [2:0] mag, input bit sg,
                           input string tag);
    cyc(0, 1, 0, 1, c, 1'b1, mag, sg, 0, 5'd0, 0, tag);
    edge_sign[c] = sg;
  endtask

  task automatic run_layer(input logic [4:0] g, input logic [2:0] mag, input bit sg,
                           input bit smp, input string tag);
    logic [4:0] pl;
    pl = g + 5'd2;
    cyc(0, 0, smp, 1, g, edge_sign[g], mag, sg, 1, pl, edge_sign[pl], tag);
    edge_sign[g] = sg;
  endtask

  task automatic probe(input logic [4:0] pl, input string tag);
    cyc(0, 0, 0, 0, 5'd0, 0, 3'd0, 0, 1, pl, edge_sign[pl], tag);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (msg_valid_o) begin
        if (exp_msg_q.size() == 0) begin
          check(1'b0, "R11 unexpected message", msg_o, 4'h0);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_msg_q.pop_front();
          t = msg_tag_q.pop_front();
          check(msg_o === e, t, msg_o, e);
        end
      end
      if (pred_valid_o) begin
        if (exp_pred_q.size() == 0) begin
          check(1'b0, "R9 unexpected prediction", pred_o, 4'h0);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_pred_q.pop_front();
          t = pred_tag_q.pop_front();
          check(pred_o === e, t, pred_o, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_i = 0; build_i = 0; simple_i = 0; valid_i = 0; layer_i = '0;
    old_sign_i = 0; new_mag_i = '0; new_sign_i = 0; pred_req_i = 0;
    pred_layer_i = '0; pred_old_sign_i = 0;
    rst_n = 0;
    mdl_clear();
    for (int k = 0; k < 32; k++) edge_sign[k] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset, empty record
    check(!msg_valid_o && !pred_valid_o, "R1 valid flags",
          {2'b0, msg_valid_o, pred_valid_o}, 4'h0);
    cyc(0, 0, 0, 0, 5'd0, 0, 3'd0, 0, 1, 5'd3, 1'b1, "R1 R6 empty record");
    probe(5'd4, "R1 R6 empty record");

    // R2: build the record over all block columns
    cyc(1, 0, 0, 0, 5'd0, 0, 3'd0, 0, 0, 5'd0, 0, "R10");
    for (int c = 0; c < 32; c++)
      build_col(5'(c), 3'((c * 5 + 3) % 8), c[0] ^ c[2], "R2");
    probe(5'd31, "R2 built record");

    // R3 R4 R5 R8 R11: full-mode sweep with look-ahead predictions
    for (int it = 0; it < 2; it++)
      for (int g = 0; g < 32; g++)
        run_layer(5'(g), 3'((g * 7 + 1 + it * 3) % 8), g[1] ^ g[3] ^ it[0], 0,
                  "R3 R4 R5 R8 R11 full sweep");

    // R7: simplified-mode sweeps
    for (int it = 0; it < 2; it++)
      for (int g = 0; g < 32; g++)
        run_layer(5'(g), 3'((g * 3 + 5 + it) % 8), g[0] ^ it[0], 1,
                  "R7 R3 R4 R8 simplified sweep");

    // R5: ties keep the earlier entry ahead; fourth value dropped
    cyc(1, 0, 0, 0, 5'd0, 0, 3'd0, 0, 0, 5'd0, 0, "R10");
    for (int c = 0; c < 5; c++) build_col(5'(c), 3'd2, 1'b0, "R5 ties");
    run_layer(5'd3, 3'd7, 1'b1, 0, "R5 tie not stored");
    run_layer(5'd0, 3'd7, 1'b0, 0, "R5 tie order");
    run_layer(5'd1, 3'd7, 1'b0, 0, "R5 tie order");
    run_layer(5'd2, 3'd7, 1'b1, 0, "R5 tie order");
    probe(5'd0, "R5 after ties");

    // R6: a single entry removed leaves an empty list
    cyc(1, 0, 0, 0, 5'd0, 0, 3'd0, 0, 0, 5'd0, 0, "R10");
    build_col(5'd5, 3'd4, 1'b1, "R6 single");
    run_layer(5'd5, 3'd6, 1'b0, 0, "R6 saturate");
    run_layer(5'd5, 3'd1, 1'b1, 0, "R6 saturate again");
    run_layer(5'd9, 3'd6, 1'b0, 0, "R6 other column");

    // R10: clear wins over a simultaneous layer input
    cyc(1, 0, 0, 1, 5'd9, 1'b1, 3'd0, 1'b1, 1, 5'd9, 1'b0, "R10 clear priority");
    probe(5'd9, "R10 emptied");
    probe(5'd5, "R10 emptied");

    repeat (4) idle();
    @(negedge clk);
    check(exp_msg_q.size() == 0 && exp_pred_q.size() == 0, "R11 all results seen",
          4'(exp_msg_q.size() + exp_pred_q.size()), 4'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule